// File: doc/BRIEF.md
# Password Unlock Sequence Checker

This block holds a 64-bit password as four 16-bit words and judges unlock attempts written to it as a fixed sequence of bus writes. A command sequencer raises `mode_active` while the password mode is entered. While that input is high, every write strobe is interpreted by a small sequencer. A write of code 0x00A0 arms a one-shot programming step. The write that follows stores its data into the word picked by the two low address bits.

An unlock attempt is seven writes: a header of 0x0025 at address 0, a word-count value at address 0, the four password words, and a trailer of 0x0029 at address 0. The word-count value is the number of password words minus one, which is 0x0003. The four words may come in any order, because each one is steered by its own address. When the trailer arrives, the block compares what was collected against the stored password. It then sets or clears the `unlocked` flag.

Stored words can be read back through a separate read port one cycle after the address is presented. Such reads return all ones while the protection-lock input is high.

Top module: `pwd_unlock_checker`

## Requirements
- R1: After reset, `unlocked` is 0 and every stored word reads back as 0xFFFF.
- R2: With `mode_active` high, a write of data 0x00A0 followed by a write at address k (0 to 3, all higher address bits zero) stores that data as word k, and a later read of address k returns it.
- R3: `rd_data` shows the word chosen by `rd_addr` one cycle after the address is presented; an address with any bit above bit 1 set reads as 0x0000.
- R4: While `prot_lock` is high, a read returns 0xFFFF regardless of address or contents.
- R5: The writes 0x0025@0, 0x0003@0, the four correct words at addresses 0..3 in any order, then 0x0029@0 set `unlocked` to 1 in the cycle after the trailer write.
- R6: A completed sequence in which any supplied word differs from the stored word clears `unlocked` to 0.
- R7: A completed sequence in which one address is written twice (so another is missing) clears `unlocked` to 0 even when all written data match.
- R8: A second header write whose value is not 0x0003 aborts the attempt; following word and trailer writes do not change `unlocked`.
- R9: A trailer write that is not 0x0029 at address 0 ends the attempt with `unlocked` unchanged.
- R10: Writes made while `mode_active` is low neither program a word nor change `unlocked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_active | input | 1 | Password mode entered by the command sequencer |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| prot_lock | input | 1 | Blocks password readback when high |
| rd_data | output | 16 | Registered read data |
| unlocked | output | 1 | Result of the last completed unlock attempt |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 16-bit words and four words. With these values the header count is 0x0003 and the code values sit well inside the word width. Because the address is 8 bits, out-of-range reads such as 0x04 and 0x83 can be tried. Four words are enough to reach reordered arrivals, duplicate addresses and single-word mismatches, and each of these is checked against a flag state that it must or must not disturb.

// File: rtl/pwd_unlock_pkg.sv
package pwd_unlock_pkg;
    localparam int unsigned PROG_CODE = 32'h00A0;
    localparam int unsigned HDR_CODE  = 32'h0025;
    localparam int unsigned TRL_CODE  = 32'h0029;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_HDR,
        ST_WORDS,
        ST_TRAIL
    } seq_state_e;
endpackage

// File: rtl/pwd_word_store.sv
module pwd_word_store #(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [$clog2(NUM_WORDS)-1:0]      widx,
    input  logic [WORD_W-1:0]                 wdata,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic                              prot_lock,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
    output logic [WORD_W-1:0]                 rd_data
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [NUM_WORDS-1:0][WORD_W-1:0] words_d, words_q;
    logic [WORD_W-1:0]                rd_d, rd_q;
    logic                             rd_in_range;

    always_comb begin
        words_d = words_q;
        if (we) begin
            words_d[widx] = wdata;
        end
        rd_in_range = (rd_addr >> IDX_W) == '0;
        if (prot_lock) begin
            rd_d = '1;
        end else if (rd_in_range) begin
            rd_d = words_q[rd_addr[IDX_W-1:0]];
        end else begin
            rd_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '1;
            rd_q    <= '1;
        end else begin
            words_q <= words_d;
            rd_q    <= rd_d;
        end
    end

    assign words   = words_q;
    assign rd_data = rd_q;
endmodule

// File: rtl/pwd_seq.sv
module pwd_seq
    import pwd_unlock_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mode_active,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
    output logic                              prog_we,
    output logic [$clog2(NUM_WORDS)-1:0]      prog_idx,
    output logic                              unlocked
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int CNT_W = $clog2(NUM_WORDS + 1);

    typedef struct packed {
        seq_state_e           state;
        logic [NUM_WORDS-1:0] seen;
        logic [NUM_WORDS-1:0] hit;
        logic                 bad;
        logic [CNT_W-1:0]     cnt;
        logic                 unlocked;
    } seq_t;

    seq_t              s_d, s_q;
    logic              addr_word_ok;
    logic              addr_zero;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        s_d          = s_q;
        idx          = wr_addr[IDX_W-1:0];
        addr_word_ok = (wr_addr >> IDX_W) == '0;
        addr_zero    = wr_addr == '0;
        prog_we      = 1'b0;
        prog_idx     = idx;
        if (!mode_active) begin
            s_d.state = ST_IDLE;
        end else if (wr_en) begin
            case (s_q.state)
                ST_IDLE: begin
                    if (wr_data == WORD_W'(PROG_CODE)) begin
                        s_d.state = ST_PROG;
                    end else if (addr_zero && wr_data == WORD_W'(HDR_CODE)) begin
                        s_d.state = ST_HDR;
                    end
                end
                ST_PROG: begin
                    prog_we   = addr_word_ok;
                    s_d.state = ST_IDLE;
                end
                ST_HDR: begin
                    if (addr_zero && wr_data == WORD_W'(NUM_WORDS - 1)) begin
                        s_d.state = ST_WORDS;
                        s_d.seen  = '0;
                        s_d.hit   = '0;
                        s_d.bad   = 1'b0;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end
                ST_WORDS: begin
                    if (!addr_word_ok || s_q.seen[idx]) begin
                        s_d.bad = 1'b1;
                    end else begin
                        s_d.seen[idx] = 1'b1;
                        s_d.hit[idx]  = (wr_data == words[idx]);
                    end
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_d.cnt == CNT_W'(NUM_WORDS)) begin
                        s_d.state = ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (addr_zero && wr_data == WORD_W'(TRL_CODE)) begin
                        s_d.unlocked = (&s_q.seen) && (&s_q.hit) && !s_q.bad;
                    end
                    s_d.state = ST_IDLE;
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.seen     <= '0;
            s_q.hit      <= '0;
            s_q.bad      <= 1'b0;
            s_q.cnt      <= '0;
            s_q.unlocked <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign unlocked = s_q.unlocked;
endmodule

// File: rtl/pwd_unlock_checker.sv
module pwd_unlock_checker #(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_active,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              prot_lock,
    output logic [WORD_W-1:0] rd_data,
    output logic              unlocked
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic                             prog_we;
    logic [IDX_W-1:0]                 prog_idx;

    pwd_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_active (mode_active),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .words       (words),
        .prog_we     (prog_we),
        .prog_idx    (prog_idx),
        .unlocked    (unlocked)
    );

    pwd_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (prog_we),
        .widx      (prog_idx),
        .wdata     (wr_data),
        .rd_addr   (rd_addr),
        .prot_lock (prot_lock),
        .words     (words),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/pwd_unlock_chk.sv
module pwd_unlock_chk #(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_active,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              prot_lock,
    input logic [WORD_W-1:0] rd_data,
    input logic              unlocked
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    p_lock_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_lock |=> rd_data == '1);

    p_high_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_lock && (rd_addr >> IDX_W) != '0) |=> rd_data == '0);

    p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(wr_en) && $past(wr_addr) == '0
                              && $past(wr_data) == WORD_W'(16'h0029)));

    p_flag_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(unlocked) |-> $past(wr_en && mode_active));

    p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_active |=> $stable(unlocked));
endmodule

bind pwd_unlock_checker pwd_unlock_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_active (mode_active),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .prot_lock   (prot_lock),
    .rd_data     (rd_data),
    .unlocked    (unlocked)
);

// File: tb/sim_pwd_unlock_checker.sv
`timescale 1ns/1ps
module sim_pwd_unlock_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_active = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic        prot_lock = 1'b0;
    logic [15:0] rd_data;
    logic        unlocked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;
    logic        pend_s = 1'b0;
    logic [15:0] pw [4] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'h5A5A};

    always #2 clk = ~clk;

    pwd_unlock_checker u0 (
        .clk(clk), .rst_n(rst_n), .mode_active(mode_active), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .prot_lock(prot_lock), .rd_data(rd_data), .unlocked(unlocked)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected read item per read request
    always @(posedge clk) pend_s <= pend;
    always @(negedge clk) begin
        if (pend_s && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        rd_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        pend = 1'b1;
        @(negedge clk);
        pend = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic attempt(logic [7:0] o0, logic [7:0] o1, logic [7:0] o2, logic [7:0] o3,
                           logic [15:0] d0, logic [15:0] d1, logic [15:0] d2, logic [15:0] d3,
                           logic [15:0] trl);
        wr(8'h00, 16'h0025);
        wr(8'h00, 16'h0003);
        wr(o0, d0); wr(o1, d1); wr(o2, d2); wr(o3, d3);
        wr(8'h00, trl);
    endtask

    task automatic good_unlock();
        attempt(0, 1, 2, 3, pw[0], pw[1], pw[2], pw[3], 16'h0029);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mode_active = 1'b1;
        @(negedge clk);
        check("R1 reset unlocked", {15'd0, unlocked}, 16'd0);
        for (int i = 0; i < 4; i++) rd(8'(i), 16'hFFFF, "R1 reset word");

        for (int i = 0; i < 4; i++) begin
            wr(8'h00, 16'h00A0);
            wr(8'(i), pw[i]);
        end
        for (int i = 3; i >= 0; i--) rd(8'(i), pw[i], "R2 readback");

        rd(8'h04, 16'h0000, "R3 high addr 04");
        rd(8'h83, 16'h0000, "R3 high addr 83");

        good_unlock();
        check("R5 in-order unlock", {15'd0, unlocked}, 16'd1);

        attempt(0, 1, 2, 3, pw[0], pw[1], 16'h0F0E, pw[3], 16'h0029);
        check("R6 mismatch clears", {15'd0, unlocked}, 16'd0);

        attempt(3, 1, 0, 2, pw[3], pw[1], pw[0], pw[2], 16'h0029);
        check("R5 reordered unlock", {15'd0, unlocked}, 16'd1);

        attempt(0, 1, 1, 3, pw[0], pw[1], pw[1], pw[3], 16'h0029);
        check("R7 duplicate address", {15'd0, unlocked}, 16'd0);

        good_unlock();
        wr(8'h00, 16'h0025);
        wr(8'h00, 16'h0002);
        wr(8'h00, 16'h1111); wr(8'h01, 16'h2222);
        wr(8'h02, 16'h3333); wr(8'h03, 16'h4444);
        wr(8'h00, 16'h0029);
        check("R8 bad count keeps flag", {15'd0, unlocked}, 16'd1);

        attempt(0, 1, 2, 3, pw[0], 16'h0000, pw[2], pw[3], 16'h0030);
        check("R9 bad trailer keeps 1", {15'd0, unlocked}, 16'd1);
        attempt(0, 1, 2, 3, pw[0], 16'h0000, pw[2], pw[3], 16'h0029);
        attempt(0, 1, 2, 3, pw[0], pw[1], pw[2], pw[3], 16'h0030);
        check("R9 bad trailer keeps 0", {15'd0, unlocked}, 16'd0);

        mode_active = 1'b0;
        wr(8'h00, 16'h00A0);
        wr(8'h01, 16'h7777);
        good_unlock();
        check("R10 inactive no unlock", {15'd0, unlocked}, 16'd0);
        mode_active = 1'b1;
        rd(8'h01, pw[1], "R10 inactive no program");

        prot_lock = 1'b1;
        rd(8'h00, 16'hFFFF, "R4 lock word0");
        rd(8'h05, 16'hFFFF, "R4 lock high addr");
        prot_lock = 1'b0;
        rd(8'h02, pw[2], "R4 unlocked read back");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule